// File: doc/BRIEF.md
# Dual-Priority Interrupt Router

This block collects a vector of interrupt source lines and steers each one onto one of two request lines toward a processor core: a normal-priority request and a fast-priority request. Each priority path has four registers on a small memory-mapped bus. There is a raw view of the sampled sources and a masked status view. There is also an enable register that only sets bits, and a companion register that only clears bits. Because of how the enable registers are written, a source can be steered to one path at most. It can also be turned off on both paths.

Software can also raise an interrupt on either path through a configuration register. These programmed interrupts go around the enable masks and always reach status, on bit 1 of the chosen path. Both request outputs are registered. Each is the OR of status bits above bit 0, so bit 0 never raises a request on its own. Source inputs pass through a register before the raw view, so a source change shows on a request two clock edges later.

Top module: `irq_route_ctrl`

## Requirements
- R1: After reset, every enable bit and both programmed-interrupt bits are zero, both request outputs are low, and every readable register reads zero while all sources are low.
- R2: The raw view of a path (normal at byte offset 0x00, fast at 0x10) shows the source inputs one clock edge after they change, whatever the enables are. Bit 1 of the raw view is also ORed with that path's programmed-interrupt bit.
- R3: The status view of a path (normal at 0x04, fast at 0x14) equals that path's raw sources ANDed bitwise with its enable register. Bit 1 also has the path's programmed bit ORed in.
- R4: The normal request output is high exactly when, one clock edge earlier, any bit from 31 down to 1 of the normal status was high. Bit 0 alone never raises it.
- R5: The fast request output follows the same rule, using bits 31 to 1 of the fast status.
- R6: Writing the enable register (normal at 0x08, fast at 0x18) sets the bits written as 1 and leaves the bits written as 0 unchanged. The enable register reads back its current value.
- R7: Writing a 1 to a bit of either enable register clears the same bit in the other path's enable register, so no bit is ever set in both at once.
- R8: Writing the clear register (normal at 0x0C, fast at 0x1C) clears the enable bits written as 1 and leaves the others unchanged. A source can end up disabled on both paths.
- R9: In the configuration register at 0x20, bit 1 sets or clears the normal path's programmed interrupt and bit 2 sets or clears the fast one. Each drives status bit 1 and its request even with every enable at zero.
- R10: Configuration bits 0 and 31 to 3 are ignored when written and read as zero.
- R11: The clear registers and unmapped offsets read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W (8) | Byte address of the register access |
| bus_wdata | input | NSRC (32) | Write data |
| bus_we | input | 1 | Write strobe, one write per high cycle |
| bus_rdata | output | NSRC (32) | Read data for bus_addr, combinational |
| src_i | input | NSRC (32) | Interrupt source lines, active high |
| norm_req_o | output | 1 | Normal-priority request to the core |
| fast_req_o | output | 1 | Fast-priority request to the core |

## Verification
The bench raises sources only on bit 0 on each path. A router that forgot to exclude bit 0 would raise a request there. It enables one bit on the fast path and then on the normal path, and checks that the fast bit drops. A design without the cross-clear would show the bit set in both enables. Writes carrying zero bits to the enable and clear registers catch a design that stores the whole word instead of setting or clearing bits. Programmed interrupts are raised with every enable at zero, which exposes a design that masks them. Configuration writes that set only reserved bits catch one that stores or decodes those bits.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

    // Byte offsets of the register map
    localparam int unsigned OFS_N_RAW  = 32'h00;
    localparam int unsigned OFS_N_STAT = 32'h04;
    localparam int unsigned OFS_N_EN   = 32'h08;
    localparam int unsigned OFS_N_CLR  = 32'h0C;
    localparam int unsigned OFS_F_RAW  = 32'h10;
    localparam int unsigned OFS_F_STAT = 32'h14;
    localparam int unsigned OFS_F_EN   = 32'h18;
    localparam int unsigned OFS_F_CLR  = 32'h1C;
    localparam int unsigned OFS_SWCFG  = 32'h20;

    // Source bit shared with programmed interrupts
    localparam int unsigned SW_BIT = 1;

    // Positions in the configuration register
    localparam int unsigned CFG_N_POS = 1;
    localparam int unsigned CFG_F_POS = 2;

    localparam int unsigned NPATH = 2;

    typedef enum logic [0:0] {
        PATH_N = 1'b0,
        PATH_F = 1'b1
    } path_e;

    typedef enum logic [2:0] {
        SEL_RAW,
        SEL_STAT,
        SEL_EN,
        SEL_CFG,
        SEL_ZERO
    } rd_sel_e;

endpackage

// File: rtl/irq_reg_decode.sv
module irq_reg_decode
    import irq_route_pkg::*;
#(
    parameter int unsigned ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    output logic [NPATH-1:0]  en_wr,
    output logic [NPATH-1:0]  clr_wr,
    output logic              cfg_wr,
    output rd_sel_e           rd_sel,
    output path_e             rd_path
);

    function automatic logic hit(input logic [ADDR_W-1:0] a, input int unsigned ofs);
        return a == ADDR_W'(ofs);
    endfunction

    always_comb begin
        en_wr   = '0;
        clr_wr  = '0;
        cfg_wr  = 1'b0;
        rd_sel  = SEL_ZERO;
        rd_path = PATH_N;

        if (hit(addr, OFS_N_RAW)) begin
            rd_sel = SEL_RAW;
        end else if (hit(addr, OFS_N_STAT)) begin
            rd_sel = SEL_STAT;
        end else if (hit(addr, OFS_N_EN)) begin
            rd_sel           = SEL_EN;
            en_wr[PATH_N]    = we;
        end else if (hit(addr, OFS_N_CLR)) begin
            clr_wr[PATH_N]   = we;
        end else if (hit(addr, OFS_F_RAW)) begin
            rd_sel  = SEL_RAW;
            rd_path = PATH_F;
        end else if (hit(addr, OFS_F_STAT)) begin
            rd_sel  = SEL_STAT;
            rd_path = PATH_F;
        end else if (hit(addr, OFS_F_EN)) begin
            rd_sel           = SEL_EN;
            rd_path          = PATH_F;
            en_wr[PATH_F]    = we;
        end else if (hit(addr, OFS_F_CLR)) begin
            clr_wr[PATH_F]   = we;
        end else if (hit(addr, OFS_SWCFG)) begin
            rd_sel = SEL_CFG;
            cfg_wr = we;
        end
    end

endmodule

// File: rtl/irq_enable_pair.sv
module irq_enable_pair
    import irq_route_pkg::*;
#(
    parameter int unsigned NSRC = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPATH-1:0] en_wr,
    input  logic [NPATH-1:0] clr_wr,
    input  logic [NSRC-1:0]  wdata,
    output logic [NSRC-1:0]  en_n,
    output logic [NSRC-1:0]  en_f
);

    typedef struct packed {
        logic [NSRC-1:0] en_n;
        logic [NSRC-1:0] en_f;
    } en_state_t;

    en_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // setting on one path strips the same bits from the other path
        if (en_wr[PATH_N]) begin
            st_d.en_n = st_q.en_n | wdata;
            st_d.en_f = st_q.en_f & ~wdata;
        end
        if (en_wr[PATH_F]) begin
            st_d.en_f = st_q.en_f | wdata;
            st_d.en_n = st_q.en_n & ~wdata;
        end
        if (clr_wr[PATH_N]) begin
            st_d.en_n = st_q.en_n & ~wdata;
        end
        if (clr_wr[PATH_F]) begin
            st_d.en_f = st_q.en_f & ~wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign en_n = st_q.en_n;
    assign en_f = st_q.en_f;

endmodule

// File: rtl/irq_path.sv
module irq_path
    import irq_route_pkg::*;
#(
    parameter int unsigned NSRC = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] src_q,
    input  logic [NSRC-1:0] en,
    input  logic            sw_irq,
    output logic [NSRC-1:0] raw,
    output logic [NSRC-1:0] stat,
    output logic            req
);

    typedef struct packed {
        logic req;
    } path_state_t;

    path_state_t st_d, st_q;

    always_comb begin
        raw          = src_q;
        raw[SW_BIT]  = src_q[SW_BIT] | sw_irq;
        stat         = src_q & en;
        // programmed interrupt bypasses the mask
        stat[SW_BIT] = (src_q[SW_BIT] & en[SW_BIT]) | sw_irq;

        st_d     = st_q;
        st_d.req = |stat[NSRC-1:1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign req = st_q.req;

endmodule

// File: rtl/irq_route_ctrl.sv
module irq_route_ctrl
    import irq_route_pkg::*;
#(
    parameter int unsigned NSRC   = 32,
    parameter int unsigned ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [NSRC-1:0]   bus_wdata,
    input  logic              bus_we,
    output logic [NSRC-1:0]   bus_rdata,
    input  logic [NSRC-1:0]   src_i,
    output logic              norm_req_o,
    output logic              fast_req_o
);

    typedef struct packed {
        logic [NSRC-1:0]  src;
        logic [NPATH-1:0] sw;
    } top_state_t;

    top_state_t st_d, st_q;

    logic [NPATH-1:0] en_wr;
    logic [NPATH-1:0] clr_wr;
    logic             cfg_wr;
    rd_sel_e          rd_sel;
    path_e            rd_path;

    logic [NSRC-1:0]  en_n;
    logic [NSRC-1:0]  en_f;
    logic [NSRC-1:0]  raw_v  [NPATH];
    logic [NSRC-1:0]  stat_v [NPATH];
    logic [NPATH-1:0] req_v;
    logic [NSRC-1:0]  stat_n;
    logic [NSRC-1:0]  stat_f;
    logic             sw_n;
    logic             sw_f;

    irq_reg_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr    (bus_addr),
        .we      (bus_we),
        .en_wr   (en_wr),
        .clr_wr  (clr_wr),
        .cfg_wr  (cfg_wr),
        .rd_sel  (rd_sel),
        .rd_path (rd_path)
    );

    irq_enable_pair #(.NSRC(NSRC)) u_en (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_wr  (en_wr),
        .clr_wr (clr_wr),
        .wdata  (bus_wdata),
        .en_n   (en_n),
        .en_f   (en_f)
    );

    always_comb begin
        st_d     = st_q;
        st_d.src = src_i;
        if (cfg_wr) begin
            st_d.sw[PATH_N] = bus_wdata[CFG_N_POS];
            st_d.sw[PATH_F] = bus_wdata[CFG_F_POS];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar gp = 0; gp < NPATH; gp++) begin : g_path
        irq_path #(.NSRC(NSRC)) u_path (
            .clk    (clk),
            .rst_n  (rst_n),
            .src_q  (st_q.src),
            .en     ((gp == int'(PATH_N)) ? en_n : en_f),
            .sw_irq (st_q.sw[gp]),
            .raw    (raw_v[gp]),
            .stat   (stat_v[gp]),
            .req    (req_v[gp])
        );
    end

    assign stat_n     = stat_v[PATH_N];
    assign stat_f     = stat_v[PATH_F];
    assign sw_n       = st_q.sw[PATH_N];
    assign sw_f       = st_q.sw[PATH_F];
    assign norm_req_o = req_v[PATH_N];
    assign fast_req_o = req_v[PATH_F];

    always_comb begin
        bus_rdata = '0;
        unique case (rd_sel)
            SEL_RAW:  bus_rdata = raw_v[rd_path];
            SEL_STAT: bus_rdata = stat_v[rd_path];
            SEL_EN:   bus_rdata = (rd_path == PATH_N) ? en_n : en_f;
            SEL_CFG: begin
                bus_rdata[CFG_N_POS] = st_q.sw[PATH_N];
                bus_rdata[CFG_F_POS] = st_q.sw[PATH_F];
            end
            default:  bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/irq_route_ctrl_chk.sv
module irq_route_ctrl_chk
    import irq_route_pkg::*;
#(
    parameter int unsigned NSRC   = 32,
    parameter int unsigned ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [NSRC-1:0]   bus_wdata,
    input logic [NSRC-1:0]   en_n,
    input logic [NSRC-1:0]   en_f,
    input logic              sw_n,
    input logic              sw_f,
    input logic [NSRC-1:0]   stat_n,
    input logic [NSRC-1:0]   stat_f,
    input logic              norm_req_o,
    input logic              fast_req_o
);

    AST_EN_DISJOINT: assert property (@(posedge clk) disable iff (!rst_n)
        (en_n & en_f) == '0); // R7

    AST_NREQ_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (|stat_n[NSRC-1:1]) |=> norm_req_o); // R4

    AST_NREQ_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !(|stat_n[NSRC-1:1]) |=> !norm_req_o); // R4

    AST_FREQ_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (|stat_f[NSRC-1:1]) |=> fast_req_o); // R5

    AST_FREQ_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !(|stat_f[NSRC-1:1]) |=> !fast_req_o); // R5

    AST_SWN_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
        sw_n |-> stat_n[SW_BIT]); // R9

    AST_SWF_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
        sw_f |-> stat_f[SW_BIT]); // R9

    AST_NEN_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == ADDR_W'(OFS_N_EN)) |=> ((en_n & $past(bus_wdata)) == $past(bus_wdata))); // R6

    AST_NCLR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == ADDR_W'(OFS_N_CLR)) |=> ((en_n & $past(bus_wdata)) == '0)); // R8

    AST_FCLR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == ADDR_W'(OFS_F_CLR)) |=> ((en_f & $past(bus_wdata)) == '0)); // R8

endmodule

bind irq_route_ctrl irq_route_ctrl_chk #(.NSRC(NSRC), .ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .en_n       (en_n),
    .en_f       (en_f),
    .sw_n       (sw_n),
    .sw_f       (sw_f),
    .stat_n     (stat_n),
    .stat_f     (stat_f),
    .norm_req_o (norm_req_o),
    .fast_req_o (fast_req_o)
);

// File: tb/irq_route_ctrl_test.sv
`timescale 1ns/1ps
module irq_route_ctrl_test;

    localparam int NSRC   = 32;
    localparam int ADDR_W = 8;

    localparam logic [7:0] A_NRAW  = 8'h00;
    localparam logic [7:0] A_NSTAT = 8'h04;
    localparam logic [7:0] A_NEN   = 8'h08;
    localparam logic [7:0] A_NCLR  = 8'h0C;
    localparam logic [7:0] A_FRAW  = 8'h10;
    localparam logic [7:0] A_FSTAT = 8'h14;
    localparam logic [7:0] A_FEN   = 8'h18;
    localparam logic [7:0] A_FCLR  = 8'h1C;
    localparam logic [7:0] A_CFG   = 8'h20;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [NSRC-1:0]   bus_wdata = '0;
    logic              bus_we = 1'b0;
    logic [NSRC-1:0]   bus_rdata;
    logic [NSRC-1:0]   src_i = '0;
    logic              norm_req_o;
    logic              fast_req_o;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    irq_route_ctrl #(.NSRC(NSRC), .ADDR_W(ADDR_W)) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_we     (bus_we),
        .bus_rdata  (bus_rdata),
        .src_i      (src_i),
        .norm_req_o (norm_req_o),
        .fast_req_o (fast_req_o)
    );

    task automatic check(input string tag, input logic [NSRC-1:0] act, input logic [NSRC-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [NSRC-1:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        @(negedge clk);
        bus_we    = 1'b0;
    endtask

    task automatic rd_check(input string tag, input logic [7:0] a, input logic [NSRC-1:0] exp);
        bus_addr = a;
        #1;
        check(tag, bus_rdata, exp);
    endtask

    // let the source register and request register both update
    task automatic settle();
        repeat (2) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wipe();
        wr(A_NCLR, '1);
        wr(A_FCLR, '1);
        wr(A_CFG, '0);
        src_i = '0;
        settle();
    endtask

    task automatic t_reset();
        rd_check("R1 normal raw",    A_NRAW,  '0);
        rd_check("R1 normal status", A_NSTAT, '0);
        rd_check("R1 normal enable", A_NEN,   '0);
        rd_check("R1 fast raw",      A_FRAW,  '0);
        rd_check("R1 fast status",   A_FSTAT, '0);
        rd_check("R1 fast enable",   A_FEN,   '0);
        rd_check("R1 config",        A_CFG,   '0);
        check("R1 normal request", 32'(norm_req_o), 32'd0);
        check("R1 fast request",   32'(fast_req_o), 32'd0);
    endtask

    task automatic t_masking();
        wr(A_NEN, 32'h0000_00F0);
        src_i = 32'h0000_0F30;
        settle();
        rd_check("R2 normal raw ignores mask", A_NRAW,  32'h0000_0F30);
        rd_check("R2 fast raw ignores mask",   A_FRAW,  32'h0000_0F30);
        rd_check("R3 normal status masked",    A_NSTAT, 32'h0000_0030);
        rd_check("R3 fast status masked",      A_FSTAT, 32'h0000_0000);
        check("R4 normal request raised", 32'(norm_req_o), 32'd1);
        check("R5 fast request idle",     32'(fast_req_o), 32'd0);
        src_i = 32'h8000_0000;
        wr(A_FEN, 32'h8000_0000);
        settle();
        rd_check("R3 fast status top bit", A_FSTAT, 32'h8000_0000);
        check("R5 fast request from bit 31", 32'(fast_req_o), 32'd1);
        check("R4 normal request dropped",   32'(norm_req_o), 32'd0);
        wipe();
    endtask

    task automatic t_bit0();
        src_i = 32'h0000_0001;
        wr(A_FEN, 32'h0000_0001);
        settle();
        rd_check("R3 fast status bit0", A_FSTAT, 32'h0000_0001);
        check("R5 bit0 raises no fast request", 32'(fast_req_o), 32'd0);
        wr(A_NEN, 32'h0000_0001);
        settle();
        rd_check("R7 fast bit0 removed", A_FEN,   32'h0000_0000);
        rd_check("R3 normal status bit0", A_NSTAT, 32'h0000_0001);
        check("R4 bit0 raises no normal request", 32'(norm_req_o), 32'd0);
        wipe();
    endtask

    task automatic t_set_and_exclusive();
        wr(A_NEN, 32'h0000_0003);
        wr(A_NEN, 32'h0000_0004);
        rd_check("R6 zero bits keep enables", A_NEN, 32'h0000_0007);
        wr(A_FEN, 32'h0000_0002);
        rd_check("R7 normal loses bit1", A_NEN, 32'h0000_0005);
        rd_check("R6 fast gains bit1",   A_FEN, 32'h0000_0002);
        wr(A_NEN, 32'h0000_0002);
        rd_check("R7 fast loses bit1",  A_FEN, 32'h0000_0000);
        rd_check("R7 normal has bit1",  A_NEN, 32'h0000_0007);
        wipe();
    endtask

    task automatic t_clear();
        wr(A_NEN, 32'h0000_00FF);
        wr(A_FEN, 32'h0000_FF00);
        wr(A_NCLR, 32'h0000_0000);
        rd_check("R8 zero clear keeps normal", A_NEN, 32'h0000_00FF);
        wr(A_NCLR, 32'h0000_0011);
        rd_check("R8 normal partial clear", A_NEN, 32'h0000_00EE);
        rd_check("R8 fast untouched",       A_FEN, 32'h0000_FF00);
        wr(A_FCLR, 32'h0000_0F00);
        rd_check("R8 fast partial clear",   A_FEN, 32'h0000_F000);
        src_i = 32'h0000_0011;
        settle();
        rd_check("R8 source off on both normal", A_NSTAT, 32'h0000_0000);
        rd_check("R8 source off on both fast",   A_FSTAT, 32'h0000_0000);
        rd_check("R11 normal clear reads zero", A_NCLR, 32'h0000_0000);
        rd_check("R11 fast clear reads zero",   A_FCLR, 32'h0000_0000);
        rd_check("R11 unmapped reads zero",     8'h40,  32'h0000_0000);
        wipe();
    endtask

    task automatic t_programmed();
        wr(A_CFG, 32'h0000_0002);
        settle();
        rd_check("R9 normal raw bit1",    A_NRAW,  32'h0000_0002);
        rd_check("R9 normal status bit1", A_NSTAT, 32'h0000_0002);
        rd_check("R9 fast status clear",  A_FSTAT, 32'h0000_0000);
        check("R9 normal request unmasked", 32'(norm_req_o), 32'd1);
        check("R9 fast request idle",       32'(fast_req_o), 32'd0);
        wr(A_CFG, 32'h0000_0004);
        settle();
        rd_check("R9 fast raw bit1",      A_FRAW,  32'h0000_0002);
        rd_check("R9 fast status bit1",   A_FSTAT, 32'h0000_0002);
        rd_check("R9 normal status gone", A_NSTAT, 32'h0000_0000);
        check("R9 fast request unmasked", 32'(fast_req_o), 32'd1);
        check("R9 normal request gone",   32'(norm_req_o), 32'd0);
        rd_check("R9 config readback", A_CFG, 32'h0000_0004);
        wr(A_CFG, 32'h0000_0000);
        settle();
        check("R9 fast request cleared", 32'(fast_req_o), 32'd0);
        wipe();
    endtask

    task automatic t_reserved();
        wr(A_CFG, 32'hFFFF_FFF9);
        settle();
        rd_check("R10 reserved bits read zero", A_CFG,   32'h0000_0000);
        rd_check("R10 no normal programmed",    A_NSTAT, 32'h0000_0000);
        rd_check("R10 no fast programmed",      A_FSTAT, 32'h0000_0000);
        check("R10 no request", 32'(norm_req_o | fast_req_o), 32'd0);
        wr(A_CFG, 32'hFFFF_FFFF);
        rd_check("R10 only bits 2 and 1 kept", A_CFG, 32'h0000_0006);
        wipe();
    endtask

    initial begin
        #(200000 * 20);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_masking();
        t_bit0();
        t_set_and_exclusive();
        t_clear();
        t_programmed();
        t_reserved();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule